// File: doc/BRIEF.md
# Maskable Interrupt Register Block

This block is a small word-addressed register file that also collects interrupt sources into one level-sensitive request line. A simple bus issues one access per cycle: a request strobe, a write flag, a word address and 32-bit write data. Reads come back one cycle later with a valid strobe. Four addresses, each set by a parameter, have special meaning. The first holds the pending (raw) interrupt bits. The second clears pending bits. The third holds the enable mask. The fourth reads back the pending bits that are enabled. Every other address inside the register range is plain storage.

Hardware event inputs set pending bits directly, in parallel with the bus. The request line is high whenever an enabled pending bit exists. A companion output pulses for one cycle after every change of that line, in either direction. Software injects interrupts by writing to the raw address. It acknowledges them through the clear address and controls which bits reach the line through the mask.

Top module: `irq_regblock`

## Requirements
- R1: A synchronous active-high reset clears the pending bits, the mask and all plain storage to zero, and drives `rd_valid`, `irq_out` and `irq_edge` low.
- R2: A write to the raw address (0) ORs the written word into the pending bits. It never clears a pending bit.
- R3: A write to the clear address (1) clears each pending bit whose written bit is 1 and leaves the others alone. A read of address 1 returns zero.
- R4: A read of the status address (3) returns pending AND mask. A write to address 3 changes neither the pending bits nor the mask.
- R5: A write to the mask address (2) stores the word. `irq_out` equals the OR-reduction of pending AND mask, taking effect in the cycle after the write edge, so unmasking a pending bit raises the line and masking it drops the line.
- R6: Addresses 4 to 7 are plain storage and read back the last value written.
- R7: A 1 on bit k of `hw_event` in a cycle sets pending bit k at that edge. If a clear of the same bit happens in that cycle, the set wins.
- R8: `irq_edge` is high for exactly one cycle, in the cycle after the one in which `irq_out` first shows a new level, for rising and falling changes alike.
- R9: With the default 8 registers, addresses 8 to 15 read zero and writes to them are dropped.
- R10: Read data appears on `rd_data` with `rd_valid` high in the cycle after the read request. `rd_valid` stays low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| hw_event | input | DATA_W (32) | Hardware set requests for pending bits |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W (32) | Registered read data |
| irq_out | output | 1 | Level interrupt request |
| irq_edge | output | 1 | One-cycle pulse after an `irq_out` change |

## Verification
The bench aims at the OR-versus-replace behaviour of raw writes. A design that replaced the word would lose earlier pending bits when a second source is injected. It writes an all-ones word to the status address and reads the mask and pending bits back. A design that treated status as storage, or aliased it to the mask, would show changed values there. It drives a hardware event and a clear onto the same bit in one cycle. A design with clear priority would silently drop that event. It also times the change pulse on both rising and falling edges of the line and checks that out-of-range writes do not alias onto low registers.

// File: rtl/irqrf_pkg.sv
package irqrf_pkg;

    // Role of an address within the block
    typedef enum logic [2:0] {
        SEL_PLAIN,
        SEL_RAW,
        SEL_CLR,
        SEL_MASK,
        SEL_STAT,
        SEL_NONE
    } sel_e;

    // Decoded bus access
    typedef struct packed {
        logic valid;
        logic we;
        sel_e sel;
    } acc_t;

    function automatic sel_e classify(
        input int unsigned a,
        input int unsigned nregs,
        input int unsigned raw_a,
        input int unsigned clr_a,
        input int unsigned mask_a,
        input int unsigned stat_a
    );
        if (a >= nregs)       return SEL_NONE;
        else if (a == raw_a)  return SEL_RAW;
        else if (a == clr_a)  return SEL_CLR;
        else if (a == mask_a) return SEL_MASK;
        else if (a == stat_a) return SEL_STAT;
        else                  return SEL_PLAIN;
    endfunction

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irqrf_decode.sv
module irqrf_decode
    import irqrf_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned RAW_A    = 0,
    parameter int unsigned CLR_A    = 1,
    parameter int unsigned MASK_A   = 2,
    parameter int unsigned STAT_A   = 3
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output acc_t              acc
);

    always_comb begin
        acc.valid = req;
        acc.we    = we;
        acc.sel   = classify(int'(addr), NUM_REGS, RAW_A, CLR_A, MASK_A, STAT_A);
    end

endmodule

// File: rtl/irqrf_pending.sv
module irqrf_pending #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              raw_wr,
    input  logic              clr_wr,
    input  logic              mask_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] hw_event,
    output logic [DATA_W-1:0] raw_q,
    output logic [DATA_W-1:0] mask_q
);

    logic [DATA_W-1:0] set_bits;
    logic [DATA_W-1:0] clr_bits;

    always_comb begin
        set_bits = hw_event | (raw_wr ? wdata : '0);
        clr_bits = clr_wr ? wdata : '0;
    end

    // Set is applied after clear so a same-cycle event survives
    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_bits) | set_bits;
            if (mask_wr) mask_q <= wdata;
        end
    end

    p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (raw_q == '0 && mask_q == '0));

    p_or_in_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(raw_wr)) |-> ((raw_q & $past(wdata)) == $past(wdata)));

    p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(raw_q) & ~$past(clr_bits) & ~raw_q) == '0));

    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((raw_q & $past(clr_bits) & ~$past(hw_event)) == '0));

    p_mask_store_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mask_wr)) |-> (mask_q == $past(wdata)));

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(hw_event) & ~raw_q) == '0));

endmodule

// File: rtl/irqrf_store.sv
module irqrf_store
    import irqrf_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned RAW_A    = 0,
    parameter int unsigned CLR_A    = 1,
    parameter int unsigned MASK_A   = 2,
    parameter int unsigned STAT_A   = 3,
    localparam int unsigned IDX_W   = idx_width(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] slot_q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        localparam bit SPECIAL = (i == RAW_A) || (i == CLR_A) ||
                                 (i == MASK_A) || (i == STAT_A);
        if (SPECIAL) begin : g_hole
            assign slot_q[i] = '0;
        end else begin : g_word
            logic [DATA_W-1:0] word_q;
            always_ff @(posedge clk) begin
                if (rst)                                 word_q <= '0;
                else if (wr_en && idx == IDX_W'(i))      word_q <= wdata;
            end
            assign slot_q[i] = word_q;
        end
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (idx == IDX_W'(k)) rd_word = slot_q[k];
        end
    end

endmodule

// File: rtl/irqrf_irqgen.sv
module irqrf_irqgen #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] raw_q,
    input  logic [DATA_W-1:0] mask_q,
    output logic              irq_out,
    output logic              irq_edge
);

    logic level_prev;

    assign irq_out = |(raw_q & mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_prev <= 1'b0;
            irq_edge   <= 1'b0;
        end else begin
            level_prev <= irq_out;
            irq_edge   <= irq_out ^ level_prev;
        end
    end

    p_edge_timing_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (irq_edge == ($past(irq_out) != $past(irq_out, 2))));

    p_quiet_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq_edge);

endmodule

// File: rtl/irq_regblock.sv
module irq_regblock
    import irqrf_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned RAW_A    = 0,
    parameter int unsigned CLR_A    = 1,
    parameter int unsigned MASK_A   = 2,
    parameter int unsigned STAT_A   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] hw_event,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_out,
    output logic              irq_edge
);

    localparam int unsigned IDX_W = idx_width(NUM_REGS);

    acc_t              acc;
    logic [DATA_W-1:0] raw_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] plain_word;
    logic [DATA_W-1:0] rd_mux;
    logic              wr_any;

    irqrf_decode #(
        .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
        .RAW_A(RAW_A), .CLR_A(CLR_A), .MASK_A(MASK_A), .STAT_A(STAT_A)
    ) u_decode (
        .req (bus_req),
        .we  (bus_we),
        .addr(bus_addr),
        .acc (acc)
    );

    assign wr_any = acc.valid && acc.we;

    irqrf_pending #(.DATA_W(DATA_W)) u_pending (
        .clk     (clk),
        .rst     (rst),
        .raw_wr  (wr_any && acc.sel == SEL_RAW),
        .clr_wr  (wr_any && acc.sel == SEL_CLR),
        .mask_wr (wr_any && acc.sel == SEL_MASK),
        .wdata   (bus_wdata),
        .hw_event(hw_event),
        .raw_q   (raw_q),
        .mask_q  (mask_q)
    );

    irqrf_store #(
        .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
        .RAW_A(RAW_A), .CLR_A(CLR_A), .MASK_A(MASK_A), .STAT_A(STAT_A)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_any && acc.sel == SEL_PLAIN),
        .idx    (bus_addr[IDX_W-1:0]),
        .wdata  (bus_wdata),
        .rd_word(plain_word)
    );

    irqrf_irqgen #(.DATA_W(DATA_W)) u_irqgen (
        .clk     (clk),
        .rst     (rst),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .irq_out (irq_out),
        .irq_edge(irq_edge)
    );

    always_comb begin
        unique case (acc.sel)
            SEL_RAW:   rd_mux = raw_q;
            SEL_MASK:  rd_mux = mask_q;
            SEL_STAT:  rd_mux = raw_q & mask_q;
            SEL_PLAIN: rd_mux = plain_word;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc.valid && !acc.we;
            if (acc.valid && !acc.we) rd_data <= rd_mux;
        end
    end

    logic addr_oor;
    assign addr_oor = ({1'b0, bus_addr} >= (ADDR_W + 1)'(NUM_REGS));

    p_rd_valid_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rd_valid == $past(bus_req && !bus_we)));

    p_oor_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rd_valid && $past(addr_oor)) |-> (rd_data == '0));

    p_stat_ro_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && int'(bus_addr) == STAT_A) |=> $stable(mask_q));

    p_reset_out_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_valid && !irq_out));

endmodule

// File: tb/irq_regblock_test.sv
`timescale 1ns/1ps
module irq_regblock_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] hw_event = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        irq_out;
    logic        irq_edge;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_regblock uut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .hw_event(hw_event),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .irq_out(irq_out), .irq_edge(irq_edge)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic        we;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{8'd2,  1'b1, 4'd0, 32'h0000_00A5, 32'h0,          1'b0}, // R2 inject
        '{8'd2,  1'b0, 4'd0, 32'h0,         32'h0000_00A5,  1'b0}, // R2
        '{8'd2,  1'b1, 4'd0, 32'h0000_0100, 32'h0,          1'b0}, // R2 OR, not replace
        '{8'd2,  1'b0, 4'd0, 32'h0,         32'h0000_01A5,  1'b0}, // R2
        '{8'd4,  1'b0, 4'd3, 32'h0,         32'h0,          1'b0}, // R4 mask zero
        '{8'd5,  1'b1, 4'd2, 32'h0000_0005, 32'h0,          1'b1}, // R5 unmask
        '{8'd4,  1'b0, 4'd3, 32'h0,         32'h0000_0005,  1'b1}, // R4
        '{8'd5,  1'b0, 4'd2, 32'h0,         32'h0000_0005,  1'b1}, // R5
        '{8'd3,  1'b1, 4'd1, 32'h0000_0004, 32'h0,          1'b1}, // R3 partial clear
        '{8'd3,  1'b0, 4'd0, 32'h0,         32'h0000_01A1,  1'b1}, // R3
        '{8'd3,  1'b1, 4'd1, 32'h0000_0001, 32'h0,          1'b0}, // R3 line drops
        '{8'd3,  1'b0, 4'd1, 32'h0,         32'h0,          1'b0}, // R3 clear reads 0
        '{8'd4,  1'b1, 4'd3, 32'hFFFF_FFFF, 32'h0,          1'b0}, // R4 write ignored
        '{8'd4,  1'b0, 4'd2, 32'h0,         32'h0000_0005,  1'b0}, // R4 mask intact
        '{8'd4,  1'b0, 4'd0, 32'h0,         32'h0000_01A0,  1'b0}, // R4 raw intact
        '{8'd6,  1'b1, 4'd4, 32'hDEAD_BEEF, 32'h0,          1'b0}, // R6
        '{8'd6,  1'b1, 4'd7, 32'h1234_5678, 32'h0,          1'b0}, // R6
        '{8'd6,  1'b0, 4'd4, 32'h0,         32'hDEAD_BEEF,  1'b0}, // R6
        '{8'd9,  1'b1, 4'd12,32'hCAFE_F00D, 32'h0,          1'b0}, // R9 dropped
        '{8'd9,  1'b0, 4'd12,32'h0,         32'h0,          1'b0}, // R9 reads 0
        '{8'd6,  1'b0, 4'd7, 32'h0,         32'h1234_5678,  1'b0}  // R6
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic do_op(input logic we, input logic [3:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 state while in reset
        chk("R1 rd_valid", {31'b0, rd_valid}, 32'h0);
        chk("R1 irq_out",  {31'b0, irq_out},  32'h0);
        chk("R1 irq_edge", {31'b0, irq_edge}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 idle rd_valid", {31'b0, rd_valid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            do_op(VECS[i].we, VECS[i].addr, VECS[i].data);
            chk($sformatf("R10 vec%0d rd_valid", i), {31'b0, rd_valid}, {31'b0, !VECS[i].we});
            if (!VECS[i].we)
                chk($sformatf("R%0d vec%0d rd_data", VECS[i].req, i), rd_data, VECS[i].exp);
            chk($sformatf("R5 vec%0d irq_out", i), {31'b0, irq_out}, {31'b0, VECS[i].exp_irq});
        end

        // R7: event and clear on same bit, set wins
        hw_event = 32'h0000_0002;
        do_op(1'b1, 4'd1, 32'h0000_0002);
        hw_event = '0;
        do_op(1'b0, 4'd0, 32'h0);
        chk("R7 set beats clear", rd_data, 32'h0000_01A2);
        // R7: event alone
        hw_event = 32'h0000_1000;
        @(negedge clk);
        hw_event = '0;
        do_op(1'b0, 4'd0, 32'h0);
        chk("R7 event sets bit", rd_data, 32'h0000_11A2);

        // R8: rising edge pulse timing
        repeat (3) @(negedge clk);
        do_op(1'b1, 4'd2, 32'h0000_0002);
        chk("R5 unmask raises", {31'b0, irq_out}, 32'h1);
        chk("R8 rise edge early", {31'b0, irq_edge}, 32'h0);
        @(negedge clk);
        chk("R8 rise pulse", {31'b0, irq_edge}, 32'h1);
        @(negedge clk);
        chk("R8 rise pulse ends", {31'b0, irq_edge}, 32'h0);
        // R8: falling edge via masking
        do_op(1'b1, 4'd2, 32'h0000_0000);
        chk("R5 mask drops", {31'b0, irq_out}, 32'h0);
        chk("R8 fall edge early", {31'b0, irq_edge}, 32'h0);
        @(negedge clk);
        chk("R8 fall pulse", {31'b0, irq_edge}, 32'h1);
        @(negedge clk);
        chk("R8 fall pulse ends", {31'b0, irq_edge}, 32'h0);

        // R1: mid-run reset clears everything
        do_op(1'b1, 4'd2, 32'h0000_0002);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 irq after reset", {31'b0, irq_out}, 32'h0);
        do_op(1'b0, 4'd0, 32'h0);
        chk("R1 raw after reset", rd_data, 32'h0);
        do_op(1'b0, 4'd2, 32'h0);
        chk("R1 mask after reset", rd_data, 32'h0);
        do_op(1'b0, 4'd4, 32'h0);
        chk("R1 plain after reset", rd_data, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule